// File: doc/BRIEF.md
# Task-File Address Remap Decoder

This block sits between a host card-access port and an ATA-style task-file register port. Each host access carries a byte offset, and the block folds that offset onto one of sixteen decoded register slots according to the addressing mode chosen by the card's option register. There are four mode folds: memory-mapped, contiguous I/O, primary I/O and secondary I/O. Most slots are passed on to the task file as a one-cycle strobe with a 3-bit register index. Three slots are served locally: the alternate-status read, the device-control write and the device-address read. The duplicate data slot and the error/feature slot are mapped onto their task-file targets.

A pass-through write that arrives while the card reports power-down raises a one-cycle wake pulse. The configuration block uses that pulse to clear the power-down bit and to set its ready pin bit. A device-control write with the soft-reset bit set raises a one-cycle soft-reset request.

The host request is a valid/ready stream that takes one access at a time. `req_ready` is high only while nothing is in flight. Every access, read or write, returns exactly one response beat on a valid/ready response stream. A response that is not taken holds `rsp_valid` and `rsp_rdata` unchanged, and no new request is accepted until it is taken. The task-file device must present read data during the cycle after its strobe.

Top module: `tf_remap_decoder`

## Requirements
- R1: Mode 0 (memory-mapped) folds offsets 0x400 to 0x7FF onto decoded slot 0. Offsets 0x000 to 0x00F keep their own value as the slot.
- R2: Mode 1 (contiguous I/O) takes the low 4 bits of any offset as the decoded slot.
- R3: Mode 2 (primary I/O) subtracts 0x1F0 from offsets 0x1F0 to 0x1FF and 0x3E8 from offsets 0x3F0 to 0x3FF. This folds 0x3F6 onto slot 0xE.
- R4: Mode 3 (secondary I/O) subtracts 0x170 from offsets 0x170 to 0x17F and 0x368 from offsets 0x370 to 0x37F. This folds 0x376 onto slot 0xE.
- R5: Slots 0x0 and 0x8 strobe task-file index 0 with the full 16-bit data. Slot 0xD strobes task-file index 1 for both reads and writes.
- R6: A read of slot 0xE strobes nothing. It returns the 8-bit drive status, zero-extended, when `drv_present` is 1, and 0 otherwise.
- R7: A write to slot 0xE strobes nothing and loads `dev_ctrl` with data bits 7:0. If data bit 2 is set, `srst_req` pulses for one cycle, in the cycle after acceptance.
- R8: A read of slot 0xF strobes nothing and returns 0xC2 OR (the inverted 4-bit `drv_sel`, shifted left by 2).
- R9: A pass-through write (slots 1 to 7, 9, 0xA to 0xC and 0xF) made while `pwr_down` is 1 pulses `wake` in the strobe cycle. Writes to slots 0, 8, 0xD and 0xE never pulse `wake`.
- R10: Each other slot goes to the task file at index slot bits 2:0 (a write to 0xF reaches index 7). A read returns `tf_rdata` as sampled in the cycle after the strobe.
- R11: If the folded value is 0x10 or more, the access has no target: no strobe, no side effect, and a read returns 0.
- R12: An accepted access strobes `tf_stb` for exactly the one cycle after acceptance. `rsp_valid` rises two cycles after the strobe, and `req_ready` stays low until the response is taken.
- R13: After reset, `req_ready` is 1 and `rsp_valid`, `tf_stb`, `wake`, `srst_req` and `dev_ctrl` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Addressing mode: 0 memory-mapped, 1 contiguous I/O, 2 primary I/O, 3 secondary I/O |
| req_valid | input | 1 | Host access request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 11 | Host byte offset |
| req_wdata | input | 16 | Host write data |
| rsp_valid | output | 1 | Response beat valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 16 | Read data (0 for writes) |
| tf_stb | output | 1 | Task-file access strobe, one cycle |
| tf_wr | output | 1 | Task-file write qualifier, valid with the strobe |
| tf_idx | output | 3 | Task-file register index |
| tf_wdata | output | 16 | Task-file write data |
| tf_rdata | input | 16 | Task-file read data, valid in the cycle after the strobe |
| drv_present | input | 1 | A drive is attached |
| drv_status | input | 8 | Drive status byte |
| drv_sel | input | 4 | Drive select value |
| pwr_down | input | 1 | Card power-down status bit |
| wake | output | 1 | One-cycle request to leave power-down |
| dev_ctrl | output | 8 | Device-control register |
| srst_req | output | 1 | One-cycle soft-reset request |

## Verification
A wrong mode fold or a wrong table entry shows at the task-file port in the first cycle after acceptance. The symptom is a missing or extra strobe, or a strobe carrying the wrong index. A wrong read mux or a stale capture shows in the first response beat, two cycles later. A corrupted device-control register shows on `dev_ctrl` right after the offending write and stays visible. Wake or soft-reset pulses are either missing or extra in the strobe cycle, so a fault there cannot outlast the access that caused it.

// File: rtl/tfr_pkg.sv
package tfr_pkg;

  localparam logic [1:0] MODE_MEM = 2'd0;
  localparam logic [1:0] MODE_LIN = 2'd1;
  localparam logic [1:0] MODE_PRI = 2'd2;
  localparam logic [1:0] MODE_SEC = 2'd3;

  // Decoded slots with dedicated behaviour
  localparam logic [3:0] SLOT_DATA_A = 4'h0;
  localparam logic [3:0] SLOT_DATA_B = 4'h8;
  localparam logic [3:0] SLOT_ERRFEAT = 4'hD;
  localparam logic [3:0] SLOT_STATCTL = 4'hE;
  localparam logic [3:0] SLOT_DEVADR = 4'hF;

  localparam logic [2:0] IDX_DATA = 3'd0;
  localparam logic [2:0] IDX_ERRFEAT = 3'd1;

  // Device-control soft-reset bit and device-address constant
  localparam int SRST_BIT = 2;
  localparam logic [7:0] DEVADR_BASE = 8'hC2;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_TF,
    TGT_STAT,
    TGT_CTRL,
    TGT_DEVADR
  } tgt_e;

  typedef struct packed {
    tgt_e tgt;
    logic [2:0] idx;
    logic wake_ok;
  } dec_t;

endpackage

// File: rtl/tfr_addr_fold.sv
module tfr_addr_fold
  import tfr_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] offs,
  output logic              hit,
  output logic [3:0]        slot
);

  localparam int MEM_SHIFT = 10;
  localparam int PAGE_SHIFT = 4;

  logic [ADDR_W-1:0] cand [4];
  logic [ADDR_W-1:0] folded;

  for (genvar m = 0; m < 4; m++) begin : g_mode
    if (m == int'(MODE_MEM)) begin : g_mem
      assign cand[m] = ((offs >> MEM_SHIFT) == ADDR_W'(1)) ? '0 : offs;
    end else if (m == int'(MODE_LIN)) begin : g_lin
      assign cand[m] = ADDR_W'(offs[3:0]);
    end else begin : g_io
      localparam int TF_PAGE = (m == int'(MODE_PRI)) ? 'h1F : 'h17;
      localparam int CT_PAGE = (m == int'(MODE_PRI)) ? 'h3F : 'h37;
      localparam int CT_SUB = (m == int'(MODE_PRI)) ? 'h3E8 : 'h368;
      localparam int TF_SUB = TF_PAGE << PAGE_SHIFT;
      logic [ADDR_W-1:0] page;
      assign page = offs >> PAGE_SHIFT;
      assign cand[m] = (page == ADDR_W'(CT_PAGE)) ? offs - ADDR_W'(CT_SUB) :
                       (page == ADDR_W'(TF_PAGE)) ? offs - ADDR_W'(TF_SUB) :
                       offs;
    end
  end

  assign folded = cand[mode];
  assign hit = (folded[ADDR_W-1:4] == '0);
  assign slot = folded[3:0];

endmodule

// File: rtl/tfr_reg_decode.sv
module tfr_reg_decode
  import tfr_pkg::*;
(
  input  logic       hit,
  input  logic [3:0] slot,
  input  logic       is_wr,
  output dec_t       dec
);

  always_comb begin
    dec.tgt = TGT_TF;
    dec.idx = slot[2:0];
    dec.wake_ok = 1'b1;
    if (!hit) begin
      dec.tgt = TGT_NONE;
      dec.wake_ok = 1'b0;
    end else begin
      unique case (slot)
        SLOT_DATA_A, SLOT_DATA_B: begin
          dec.idx = IDX_DATA;
          dec.wake_ok = 1'b0;
        end
        SLOT_ERRFEAT: begin
          dec.idx = IDX_ERRFEAT;
          dec.wake_ok = 1'b0;
        end
        SLOT_STATCTL: begin
          dec.tgt = is_wr ? TGT_CTRL : TGT_STAT;
          dec.wake_ok = 1'b0;
        end
        SLOT_DEVADR: begin
          if (!is_wr) begin
            dec.tgt = TGT_DEVADR;
            dec.wake_ok = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/tfr_seq.sv
module tfr_seq
  import tfr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STAT_W = 8,
  parameter int SEL_W = 4,
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  dec_t              dec,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              tf_stb,
  output logic              tf_wr,
  output logic [2:0]        tf_idx,
  output logic [DATA_W-1:0] tf_wdata,
  input  logic [DATA_W-1:0] tf_rdata,
  input  logic              drv_present,
  input  logic [STAT_W-1:0] drv_status,
  input  logic [SEL_W-1:0]  drv_sel,
  input  logic              pwr_down,
  output logic              wake,
  output logic [CTRL_W-1:0] dev_ctrl,
  output logic              srst_req
);

  typedef enum logic [1:0] {S_IDLE, S_STB, S_CAP, S_RSP} st_e;

  localparam int DEVADR_W = SEL_W + 4;

  st_e               st_q;
  tgt_e              tgt_q;
  logic              wr_q;
  logic              stb_q;
  logic [2:0]        idx_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wake_q;
  logic              srst_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] rsp_q;
  logic              accept;
  logic [DATA_W-1:0] rd_mux;
  logic [DEVADR_W-1:0] devadr;

  assign req_ready = (st_q == S_IDLE);
  assign accept = req_valid && req_ready;
  assign devadr = DEVADR_W'(DEVADR_BASE) | {2'b00, ~drv_sel, 2'b00};

  always_comb begin
    unique case (tgt_q)
      TGT_TF:     rd_mux = tf_rdata;
      TGT_STAT:   rd_mux = drv_present ? DATA_W'(drv_status) : '0;
      TGT_DEVADR: rd_mux = DATA_W'(devadr);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      tgt_q <= TGT_NONE;
      wr_q <= 1'b0;
      stb_q <= 1'b0;
      idx_q <= '0;
      wdata_q <= '0;
      wake_q <= 1'b0;
      srst_q <= 1'b0;
      ctrl_q <= '0;
      rsp_q <= '0;
    end else begin
      stb_q <= 1'b0;
      wake_q <= 1'b0;
      srst_q <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (accept) begin
            st_q <= S_STB;
            tgt_q <= dec.tgt;
            wr_q <= req_write;
            stb_q <= (dec.tgt == TGT_TF);
            idx_q <= dec.idx;
            wdata_q <= req_wdata;
            wake_q <= req_write && (dec.tgt == TGT_TF) && dec.wake_ok && pwr_down;
            if (dec.tgt == TGT_CTRL) begin
              ctrl_q <= req_wdata[CTRL_W-1:0];
              srst_q <= req_wdata[SRST_BIT];
            end
          end
        end
        S_STB: st_q <= S_CAP;
        S_CAP: begin
          st_q <= S_RSP;
          rsp_q <= wr_q ? '0 : rd_mux;
        end
        S_RSP: if (rsp_ready) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign rsp_valid = (st_q == S_RSP);
  assign rsp_rdata = rsp_q;
  assign tf_stb = stb_q;
  assign tf_wr = wr_q;
  assign tf_idx = idx_q;
  assign tf_wdata = wdata_q;
  assign wake = wake_q;
  assign srst_req = srst_q;
  assign dev_ctrl = ctrl_q;

  // R12: strobe lasts one cycle and only follows an accepted request
  p_stb_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tf_stb |=> !tf_stb);
  p_stb_after_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tf_stb |-> $past(req_valid && req_ready));
  // R12: a response beat not taken stays unchanged
  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  // R9: wake only accompanies a task-file write strobe
  p_wake_with_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (tf_stb && tf_wr));
  // R7: soft-reset request only when the stored control has the reset bit
  p_srst_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    srst_req |-> dev_ctrl[SRST_BIT]);

endmodule

// File: rtl/tf_remap_decoder.sv
module tf_remap_decoder
  import tfr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16,
  parameter int STAT_W = 8,
  parameter int SEL_W = 4,
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              tf_stb,
  output logic              tf_wr,
  output logic [2:0]        tf_idx,
  output logic [DATA_W-1:0] tf_wdata,
  input  logic [DATA_W-1:0] tf_rdata,
  input  logic              drv_present,
  input  logic [STAT_W-1:0] drv_status,
  input  logic [SEL_W-1:0]  drv_sel,
  input  logic              pwr_down,
  output logic              wake,
  output logic [CTRL_W-1:0] dev_ctrl,
  output logic              srst_req
);

  logic       fold_hit;
  logic [3:0] fold_slot;
  dec_t       dec;

  tfr_addr_fold #(.ADDR_W(ADDR_W)) u_fold (
    .mode (mode),
    .offs (req_addr),
    .hit  (fold_hit),
    .slot (fold_slot)
  );

  tfr_reg_decode u_dec (
    .hit   (fold_hit),
    .slot  (fold_slot),
    .is_wr (req_write),
    .dec   (dec)
  );

  tfr_seq #(
    .DATA_W(DATA_W), .STAT_W(STAT_W), .SEL_W(SEL_W), .CTRL_W(CTRL_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_wdata   (req_wdata),
    .dec         (dec),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_rdata   (rsp_rdata),
    .tf_stb      (tf_stb),
    .tf_wr       (tf_wr),
    .tf_idx      (tf_idx),
    .tf_wdata    (tf_wdata),
    .tf_rdata    (tf_rdata),
    .drv_present (drv_present),
    .drv_status  (drv_status),
    .drv_sel     (drv_sel),
    .pwr_down    (pwr_down),
    .wake        (wake),
    .dev_ctrl    (dev_ctrl),
    .srst_req    (srst_req)
  );

  // R2: the contiguous mode always lands inside the sixteen slots
  p_lin_hits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == MODE_LIN) |-> fold_hit);
  // R11 / R6: accesses without a task-file target never strobe
  p_local_no_stb_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && dec.tgt != TGT_TF) |=> !tf_stb);

endmodule

// File: tb/tf_remap_decoder_tb.sv
`timescale 1ns/1ps
module tf_remap_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [10:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [15:0] rsp_rdata;
  logic        tf_stb;
  logic        tf_wr;
  logic [2:0]  tf_idx;
  logic [15:0] tf_wdata;
  logic [15:0] tf_rdata = '0;
  logic        drv_present = 1'b1;
  logic [7:0]  drv_status = '0;
  logic [3:0]  drv_sel = '0;
  logic        pwr_down = 1'b0;
  logic        wake;
  logic [7:0]  dev_ctrl;
  logic        srst_req;

  int checks = 0;
  int errors = 0;
  int exp_ctrl = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tf_remap_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .tf_stb(tf_stb), .tf_wr(tf_wr), .tf_idx(tf_idx), .tf_wdata(tf_wdata),
    .tf_rdata(tf_rdata), .drv_present(drv_present), .drv_status(drv_status),
    .drv_sel(drv_sel), .pwr_down(pwr_down), .wake(wake),
    .dev_ctrl(dev_ctrl), .srst_req(srst_req)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Expected slot from the fold rules; -1 means no target
  function automatic int bfold(input int md, input int a);
    int r;
    r = a;
    case (md)
      0: if (a >= 'h400 && a <= 'h7FF) r = 0;
      1: r = a % 16;
      2: if (a >= 'h1F0 && a <= 'h1FF) r = a - 'h1F0;
         else if (a >= 'h3F0 && a <= 'h3FF) r = a - 'h3E8;
      default: if (a >= 'h170 && a <= 'h17F) r = a - 'h170;
               else if (a >= 'h370 && a <= 'h37F) r = a - 'h368;
    endcase
    return (r > 15) ? -1 : r;
  endfunction

  task automatic access(input int md, input bit wr, input int a, input int wd,
                        input int hold, input string rq);
    int r;
    bit estb;
    bit ewake;
    bit esrst;
    int eidx;
    int erd;
    r = bfold(md, a);
    estb = 0; ewake = 0; esrst = 0; eidx = 0; erd = 0;
    if (r < 0) begin
      estb = 0;
    end else if (r == 0 || r == 8) begin
      estb = 1; eidx = 0; erd = tf_rdata;
    end else if (r == 13) begin
      estb = 1; eidx = 1; erd = tf_rdata;
    end else if (r == 14) begin
      if (wr) esrst = wd[2];
      else erd = drv_present ? int'(drv_status) : 0;
    end else if (r == 15 && !wr) begin
      erd = 'hC2 | ((~int'(drv_sel) << 2) & 'h3C);
    end else begin
      estb = 1; eidx = r % 8; erd = tf_rdata; ewake = wr && pwr_down;
    end
    if (wr) erd = 0;

    @(negedge clk);
    mode = md[1:0]; req_write = wr; req_addr = a[10:0];
    req_wdata = wd[15:0]; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R12", "req_ready idle", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(tf_stb == estb, rq, "strobe", int'(tf_stb), int'(estb));
    if (estb) begin
      chk(tf_idx == eidx[2:0], rq, "index", int'(tf_idx), eidx);
      chk(tf_wr == wr, rq, "direction", int'(tf_wr), int'(wr));
      if (wr) chk(tf_wdata == wd[15:0], rq, "wdata", int'(tf_wdata), wd);
    end
    chk(wake == ewake, "R9", "wake pulse", int'(wake), int'(ewake));
    chk(srst_req == esrst, "R7", "srst pulse", int'(srst_req), int'(esrst));
    if (r == 14 && wr) exp_ctrl = wd & 'hFF;
    @(negedge clk);
    chk(tf_stb == 1'b0, "R12", "strobe one cycle", int'(tf_stb), 0);
    chk(wake == 1'b0 && srst_req == 1'b0, "R12", "pulse one cycle",
        int'(wake | srst_req), 0);
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R12", "rsp_valid", int'(rsp_valid), 1);
    chk(rsp_rdata == erd[15:0], rq, "rdata", int'(rsp_rdata), erd);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == erd[15:0] && !req_ready, "R12",
          "held response", int'(rsp_rdata), erd);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R12", "response taken",
        int'({rsp_valid, req_ready}), 1);
    chk(dev_ctrl == exp_ctrl[7:0], "R7", "dev_ctrl", int'(dev_ctrl), exp_ctrl);
  endtask

  function automatic string mode_req(input int md);
    case (md)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    int seed_init;
    seed_init = $urandom(32'd4660);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(req_ready == 1'b1, "R13", "req_ready", int'(req_ready), 1);
    chk(!rsp_valid && !tf_stb && !wake && !srst_req, "R13", "outputs idle",
        int'({rsp_valid, tf_stb, wake, srst_req}), 0);
    chk(dev_ctrl == 8'h00, "R13", "dev_ctrl", int'(dev_ctrl), 0);

    // Directed corners
    tf_rdata = 16'hBEEF; drv_status = 8'h50; drv_sel = 4'h5;
    access(0, 0, 'h5A3, 0, 0, "R1");
    access(0, 0, 'h00D, 0, 0, "R5");
    access(0, 0, 'h010, 0, 0, "R11");
    access(1, 1, 'h7F8, 'h1234, 0, "R2");
    access(2, 0, 'h3F6, 0, 0, "R3");
    access(2, 0, 'h3F6, 0, 0, "R6");
    drv_present = 1'b0;
    access(2, 0, 'h3F6, 0, 0, "R6");
    drv_present = 1'b1;
    access(3, 1, 'h376, 'h0004, 0, "R4");
    access(3, 1, 'h376, 'h0002, 0, "R7");
    access(2, 0, 'h3F7, 0, 0, "R8");
    access(2, 0, 'h3FA, 0, 0, "R11");
    access(3, 0, 'h172, 0, 0, "R10");
    pwr_down = 1'b1;
    access(1, 1, 'h003, 'h00AA, 0, "R9");
    access(1, 1, 'h000, 'h00AA, 0, "R9");
    access(2, 1, 'h1FF, 'h00E0, 0, "R9");
    pwr_down = 1'b0;
    access(1, 0, 'h00C, 0, 3, "R12");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int md;
      int a;
      int pick;
      bit wr;
      md = int'($urandom % 4);
      pick = int'($urandom % 6);
      case (pick)
        0: a = int'($urandom % 2048);
        1: a = 'h1F0 + int'($urandom % 16);
        2: a = 'h3F0 + int'($urandom % 16);
        3: a = 'h170 + int'($urandom % 16);
        4: a = 'h370 + int'($urandom % 16);
        default: a = 'h400 + int'($urandom % 1024);
      endcase
      wr = 1'($urandom % 2);
      tf_rdata = 16'($urandom);
      drv_status = 8'($urandom);
      drv_sel = 4'($urandom);
      drv_present = 1'($urandom % 2);
      pwr_down = 1'($urandom % 2);
      access(md, wr, a, int'($urandom % 65536), int'($urandom % 3), mode_req(md));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R12 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule